// File: doc/BRIEF.md
# Byte-Accounted Two-Level Egress Scheduler

This block picks which queue of an egress port sends its next frame. The queues form two levels. Eight work queues sit at the top level, and each work queue holds a fixed number of frame queues. Every cycle the block looks at which frame queues hold a frame and how long each head frame is. It then decides in one clock whether a frame leaves, and from which queue. The decision comes out one cycle later as a grant pulse, the work-queue and frame-queue indices, and a one-hot dequeue strobe over all frame queues.

Each work queue has two token buckets that hold a byte count, signed so it can go below zero. The committed bucket decides whether the class is served first. The excess bucket decides whether it may still be served after that. Both buckets are charged the full frame length on a grant, refilled by their programmed rate on every `tick_i` pulse, and held at or below their programmed burst size. The host chooses the tick period so that one rate unit equals 1 Kbps. The 24-bit rate field then covers 1 Kbps up to beyond 10 Gbps. Within each bucket tier, strict-priority classes come before weighted classes. Weighted classes share the port by deficit round robin, counted in bytes. Inside a work queue the frame queues take turns round robin.

A host write on the configuration port sets the mode, weight, rates and burst sizes of one work queue.

Top module: `egress_sched`

## Requirements
- R1: After reset, `grant_o` is low and `deq_o` is zero. Every bucket and deficit holds 0, every pointer holds index 0, and every rate and burst is 0. Every work queue is weighted with weight 1.
- R2: A decision made on inputs at clock edge k shows at the outputs after edge k and lasts one cycle. While `grant_o` is high, `deq_o` has exactly one bit set, at bit `grant_wq_o*FQ_PER_WQ + grant_fq_o`. While `grant_o` is low, `deq_o` is zero.
- R3: A work queue whose committed bucket is zero or more is in the committed tier. A work queue whose committed bucket is below zero but whose excess bucket is zero or more is in the excess tier. Any backlogged committed-tier queue is chosen before any excess-tier queue. A queue with both buckets below zero is never granted.
- R4: Within a tier, backlogged strict-mode work queues come before weighted ones, and among strict ones the lowest index wins.
- R5: Among weighted queues of the chosen tier, the scheduler takes the first backlogged queue at or after the round-robin pointer. If that queue's deficit is at least its head frame length, it is granted, its deficit drops by the length, and the pointer stays on it. Otherwise there is no grant that cycle, the deficit grows by weight × `BASE_Q`, and the pointer moves to the next index. A deficit is cleared while the queue is empty, strict, or being configured.
- R6: Inside a work queue, the frame queue granted is the first backlogged one at or after that work queue's pointer. After each grant of that work queue, the pointer moves to the index just past the granted frame queue.
- R7: Each bucket's next value is current − (length if granted) + (rate if `tick_i`), capped at its burst size. A refill and a debit in the same cycle are both applied.
- R8: Only a frame queue whose `fq_backlog_i` bit was set is ever dequeued. With no backlog there is no grant.
- R9: A write with `cfg_we_i` high loads the addressed work queue's mode, weight, rates and bursts. It sets both buckets to their burst sizes and clears that queue's deficit. The decision in the same cycle still uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Refill pulse for all buckets |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wq_i | input | 3 | Work queue addressed by the write |
| cfg_strict_i | input | 1 | 1 = strict mode, 0 = weighted |
| cfg_weight_i | input | 4 | DRR weight (must be nonzero) |
| cfg_cir_i | input | 24 | Committed refill, bytes per tick |
| cfg_eir_i | input | 24 | Excess refill, bytes per tick |
| cfg_cbs_i | input | 24 | Committed burst cap, bytes |
| cfg_ebs_i | input | 24 | Excess burst cap, bytes |
| fq_backlog_i | input | 32 | Per frame queue: a frame is waiting |
| fq_head_len_i | input | 512 | 16-bit head frame length per frame queue, queue j at bits [16j+15:16j] |
| grant_o | output | 1 | One-cycle grant pulse |
| grant_wq_o | output | 3 | Granted work queue |
| grant_fq_o | output | 2 | Granted frame queue within it |
| deq_o | output | 32 | One-hot dequeue strobe |

## Verification
A bucket refill from `tick_i` and a debit from a grant can hit the same bucket on the same edge. A host write can also land in a cycle where a grant is being decided. The bench forces the first case by pulsing `tick_i` every cycle while every queue stays backlogged with small burst caps, so that the tier of each class flips often. It forces the second case by issuing writes while traffic flows. A byte-level model in the bench tracks every bucket, deficit and pointer. It applies both effects in the order the requirements give, and each following grant, index and strobe is compared with that model.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int LEN_W   = 16;
  localparam int RATE_W  = 24;
  localparam int BURST_W = 24;
  localparam int WGT_W   = 4;
  localparam int BKT_W   = BURST_W + 2;
  localparam int DEF_W   = LEN_W + 4;

  typedef logic signed [BKT_W-1:0] bkt_t;

  // Bucket step: charge, refill, then clamp at the burst cap.
  function automatic bkt_t bkt_next(input bkt_t cur, input logic [LEN_W-1:0] charge,
                                    input logic [RATE_W-1:0] add, input logic [BURST_W-1:0] cap);
    bkt_t t;
    t = cur - bkt_t'({1'b0, charge}) + bkt_t'({1'b0, add});
    if (t > bkt_t'({1'b0, cap})) t = bkt_t'({1'b0, cap});
    return t;
  endfunction

  function automatic logic [DEF_W-1:0] quantum(input logic [WGT_W-1:0] w, input int unsigned base);
    return DEF_W'(w) * DEF_W'(base);
  endfunction
endpackage

// File: rtl/es_shaper.sv
module es_shaper import es_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [RATE_W-1:0]  cir,
  input  logic [RATE_W-1:0]  eir,
  input  logic [BURST_W-1:0] cbs,
  input  logic [BURST_W-1:0] ebs,
  input  logic               tick,
  input  logic               debit,
  input  logic [LEN_W-1:0]   len,
  output logic               commit_ok,
  output logic               excess_ok
);
  logic [RATE_W-1:0]  cir_q, eir_q;
  logic [BURST_W-1:0] cbs_q, ebs_q;
  bkt_t c_bkt, e_bkt;
  logic [LEN_W-1:0]   charge;

  assign charge = debit ? len : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cir_q <= '0; eir_q <= '0; cbs_q <= '0; ebs_q <= '0;
      c_bkt <= '0; e_bkt <= '0;
    end else if (load) begin
      cir_q <= cir; eir_q <= eir; cbs_q <= cbs; ebs_q <= ebs;
      c_bkt <= bkt_t'({1'b0, cbs});
      e_bkt <= bkt_t'({1'b0, ebs});
    end else begin
      c_bkt <= bkt_next(c_bkt, charge, tick ? cir_q : '0, cbs_q);
      e_bkt <= bkt_next(e_bkt, charge, tick ? eir_q : '0, ebs_q);
    end
  end

  assign commit_ok = !c_bkt[BKT_W-1];
  assign excess_ok = !e_bkt[BKT_W-1];

  assert_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_bkt <= bkt_t'({1'b0, cbs_q})) && (e_bkt <= bkt_t'({1'b0, ebs_q})));
  assert_debit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (debit && !tick && !load) |=> (c_bkt == $past(c_bkt) - bkt_t'({1'b0, $past(len)})));
endmodule

// File: rtl/es_fq_pick.sv
module es_fq_pick import es_pkg::*; #(
  parameter  int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       backlog,
  input  logic [N*LEN_W-1:0] lens,
  input  logic               adv,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [LEN_W-1:0]   len
);
  logic [IDX_W-1:0] ptr;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!any && backlog[(int'(ptr) + k) % N]) begin
        any = 1'b1;
        idx = IDX_W'((int'(ptr) + k) % N);
      end
    end
    len = lens[int'(idx)*LEN_W +: LEN_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (int'(idx) == N-1) ? '0 : idx + 1'b1;
  end

  assert_adv_backlog_R6: assert property (@(posedge clk) disable iff (!rst_n) adv |-> any);
endmodule

// File: rtl/es_wq_arb.sv
module es_wq_arb import es_pkg::*; #(
  parameter  int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       active,
  input  logic [N-1:0]       commit_ok,
  input  logic [N-1:0]       excess_ok,
  input  logic [N-1:0]       strict,
  input  logic [N-1:0]       clear,
  input  logic [N*LEN_W-1:0] lens,
  input  logic [N*DEF_W-1:0] quanta,
  output logic               grant,
  output logic [IDX_W-1:0]   gidx,
  output logic               replenish
);
  logic [DEF_W-1:0] deficit [N];
  logic [IDX_W-1:0] wptr;
  logic [N-1:0]     cand_cs, cand_cw, cand_es, cand_ew, drr_set;
  logic             use_drr, drr_found, drr_fit;
  logic [IDX_W-1:0] drr_pick;

  function automatic logic [IDX_W-1:0] lowest(input logic [N-1:0] s);
    lowest = '0;
    for (int k = N-1; k >= 0; k--) if (s[k]) lowest = IDX_W'(k);
  endfunction

  always_comb begin
    cand_cs = active &  commit_ok &  strict;
    cand_cw = active &  commit_ok & ~strict;
    cand_es = active & ~commit_ok & excess_ok &  strict;
    cand_ew = active & ~commit_ok & excess_ok & ~strict;
    drr_set = (|cand_cw) ? cand_cw : cand_ew;
    use_drr = !(|cand_cs) && ((|cand_cw) || (!(|cand_es) && (|cand_ew)));
  end

  always_comb begin
    drr_found = 1'b0;
    drr_pick  = '0;
    for (int k = 0; k < N; k++) begin
      if (!drr_found && drr_set[(int'(wptr) + k) % N]) begin
        drr_found = 1'b1;
        drr_pick  = IDX_W'((int'(wptr) + k) % N);
      end
    end
    drr_fit = deficit[drr_pick] >= DEF_W'(lens[int'(drr_pick)*LEN_W +: LEN_W]);
  end

  always_comb begin
    grant = 1'b0; gidx = '0; replenish = 1'b0;
    if (|cand_cs) begin
      grant = 1'b1; gidx = lowest(cand_cs);
    end else if (use_drr) begin
      if (drr_fit) begin grant = 1'b1; gidx = drr_pick; end
      else replenish = 1'b1;
    end else if (|cand_es) begin
      grant = 1'b1; gidx = lowest(cand_es);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < N; i++) deficit[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (clear[i] || !active[i] || strict[i])
          deficit[i] <= '0;
        else if (use_drr && grant && drr_pick == IDX_W'(i))
          deficit[i] <= deficit[i] - DEF_W'(lens[i*LEN_W +: LEN_W]);
        else if (replenish && drr_pick == IDX_W'(i))
          deficit[i] <= deficit[i] + quanta[i*DEF_W +: DEF_W];
      end
      if (use_drr)
        wptr <= grant ? drr_pick : ((int'(drr_pick) == N-1) ? '0 : drr_pick + 1'b1);
    end
  end

  assert_tier_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !commit_ok[gidx]) |-> !(|(active & commit_ok)));
  assert_strict_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand_cs) |-> (grant && strict[gidx] && commit_ok[gidx]));
  assert_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (active[gidx] && (commit_ok[gidx] || excess_ok[gidx])));
  assert_refill_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    replenish |-> !grant);
endmodule

// File: rtl/egress_sched.sv
module egress_sched import es_pkg::*; #(
  parameter  int NUM_WQ    = 8,
  parameter  int FQ_PER_WQ = 4,
  parameter  int BASE_Q    = 64,
  localparam int NUM_FQ    = NUM_WQ * FQ_PER_WQ,
  localparam int WQ_W      = (NUM_WQ > 1) ? $clog2(NUM_WQ) : 1,
  localparam int FQ_W      = (FQ_PER_WQ > 1) ? $clog2(FQ_PER_WQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic                    cfg_we_i,
  input  logic [WQ_W-1:0]         cfg_wq_i,
  input  logic                    cfg_strict_i,
  input  logic [WGT_W-1:0]        cfg_weight_i,
  input  logic [RATE_W-1:0]       cfg_cir_i,
  input  logic [RATE_W-1:0]       cfg_eir_i,
  input  logic [BURST_W-1:0]      cfg_cbs_i,
  input  logic [BURST_W-1:0]      cfg_ebs_i,
  input  logic [NUM_FQ-1:0]       fq_backlog_i,
  input  logic [NUM_FQ*LEN_W-1:0] fq_head_len_i,
  output logic                    grant_o,
  output logic [WQ_W-1:0]         grant_wq_o,
  output logic [FQ_W-1:0]         grant_fq_o,
  output logic [NUM_FQ-1:0]       deq_o
);
  logic [NUM_WQ-1:0]       wq_active, wq_commit, wq_excess, wq_strict, wq_load, wq_take;
  logic [NUM_WQ*LEN_W-1:0] wq_len;
  logic [NUM_WQ*DEF_W-1:0] wq_quantum;
  logic [FQ_W-1:0]         wq_fq [NUM_WQ];
  logic [WGT_W-1:0]        weight_q [NUM_WQ];
  logic                    arb_grant, arb_replenish;
  logic [WQ_W-1:0]         arb_wq;

  for (genvar g = 0; g < NUM_WQ; g++) begin : g_wq
    assign wq_load[g] = cfg_we_i && (cfg_wq_i == WQ_W'(g));
    assign wq_take[g] = arb_grant && (arb_wq == WQ_W'(g));
    assign wq_quantum[g*DEF_W +: DEF_W] = quantum(weight_q[g], BASE_Q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wq_strict[g] <= 1'b0;
        weight_q[g]  <= WGT_W'(1);
      end else if (wq_load[g]) begin
        wq_strict[g] <= cfg_strict_i;
        weight_q[g]  <= cfg_weight_i;
      end
    end

    es_fq_pick #(.N(FQ_PER_WQ)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .backlog (fq_backlog_i[g*FQ_PER_WQ +: FQ_PER_WQ]),
      .lens    (fq_head_len_i[g*FQ_PER_WQ*LEN_W +: FQ_PER_WQ*LEN_W]),
      .adv     (wq_take[g]),
      .any     (wq_active[g]),
      .idx     (wq_fq[g]),
      .len     (wq_len[g*LEN_W +: LEN_W])
    );

    es_shaper u_shaper (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wq_load[g]),
      .cir       (cfg_cir_i),
      .eir       (cfg_eir_i),
      .cbs       (cfg_cbs_i),
      .ebs       (cfg_ebs_i),
      .tick      (tick_i),
      .debit     (wq_take[g]),
      .len       (wq_len[g*LEN_W +: LEN_W]),
      .commit_ok (wq_commit[g]),
      .excess_ok (wq_excess[g])
    );
  end

  es_wq_arb #(.N(NUM_WQ)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (wq_active),
    .commit_ok (wq_commit),
    .excess_ok (wq_excess),
    .strict    (wq_strict),
    .clear     (wq_load),
    .lens      (wq_len),
    .quanta    (wq_quantum),
    .grant     (arb_grant),
    .gidx      (arb_wq),
    .replenish (arb_replenish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_o    <= 1'b0;
      grant_wq_o <= '0;
      grant_fq_o <= '0;
      deq_o      <= '0;
    end else begin
      grant_o    <= arb_grant;
      grant_wq_o <= arb_wq;
      grant_fq_o <= wq_fq[arb_wq];
      deq_o      <= arb_grant
                  ? (NUM_FQ'(1) << (int'(arb_wq)*FQ_PER_WQ + int'(wq_fq[arb_wq])))
                  : '0;
    end
  end

  assert_deq_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> ($countones(deq_o) == 1));
  assert_deq_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_o |-> (deq_o == '0));
  assert_backlogged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (|($past(fq_backlog_i) & deq_o)));
  assert_no_double_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_replenish |=> !grant_o);
endmodule

// File: tb/egress_sched_tb.sv
module egress_sched_tb;
  import es_pkg::*;
  localparam int NW = 8, NF = 4, NQ = 32, BQ = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, cfg_we_i = 1'b0, cfg_strict_i = 1'b0;
  logic [2:0] cfg_wq_i = '0;
  logic [WGT_W-1:0] cfg_weight_i = '0;
  logic [RATE_W-1:0] cfg_cir_i = '0, cfg_eir_i = '0;
  logic [BURST_W-1:0] cfg_cbs_i = '0, cfg_ebs_i = '0;
  logic [NQ-1:0] fq_backlog_i = '0;
  logic [NQ*LEN_W-1:0] fq_head_len_i = '0;
  logic grant_o;
  logic [2:0] grant_wq_o;
  logic [1:0] grant_fq_o;
  logic [NQ-1:0] deq_o;

  always #10 clk = ~clk;

  egress_sched u_dut (.*);

  typedef struct { bit g; int wq; int fq; } exp_t;
  exp_t sbq[$];
  int checks = 0, failures = 0;
  string tag = "R1";
  bit done = 0;

  // stimulus for the coming edge
  bit n_rst = 0, n_tick = 0, n_we = 0, n_strict = 0;
  int n_wq = 0, n_wgt = 0, n_cir = 0, n_eir = 0, n_cbs = 0, n_ebs = 0;
  bit [NQ-1:0] n_bl = '0;
  int n_len[NQ];

  // byte-level model
  int cb[NW], eb[NW], dfc[NW], fqp[NW], wgt[NW], cir[NW], eir[NW], cbs[NW], ebs[NW];
  bit strm[NW];
  int wptr;
  bit [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string t, input string what, input int act, input int ex);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, ex, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NW; i++) begin
      cb[i] = 0; eb[i] = 0; dfc[i] = 0; fqp[i] = 0; wgt[i] = 1; strm[i] = 0;
      cir[i] = 0; eir[i] = 0; cbs[i] = 0; ebs[i] = 0;
    end
    wptr = 0;
  endtask

  task automatic predict();
    bit act[NW]; int pf[NW], pl[NW];
    bit [NW-1:0] cs, cw, es, ew, set;
    bit g = 0, drr = 0, rep = 0; int gw = 0, f = 0; exp_t e;
    for (int w = 0; w < NW; w++) begin
      act[w] = 0; pf[w] = 0; pl[w] = 0;
      for (int k = 0; k < NF; k++) begin
        int j = (fqp[w] + k) % NF;
        if (!act[w] && n_bl[w*NF+j]) begin act[w] = 1; pf[w] = j; pl[w] = n_len[w*NF+j]; end
      end
      cs[w] = act[w] && cb[w] >= 0 && strm[w];
      cw[w] = act[w] && cb[w] >= 0 && !strm[w];
      es[w] = act[w] && cb[w] < 0 && eb[w] >= 0 && strm[w];
      ew[w] = act[w] && cb[w] < 0 && eb[w] >= 0 && !strm[w];
    end
    set = '0;
    if (cs != 0) begin g = 1; for (int w = NW-1; w >= 0; w--) if (cs[w]) gw = w; end
    else if (cw != 0) begin drr = 1; set = cw; end
    else if (es != 0) begin g = 1; for (int w = NW-1; w >= 0; w--) if (es[w]) gw = w; end
    else if (ew != 0) begin drr = 1; set = ew; end
    if (drr) begin
      bit fnd = 0;
      for (int k = 0; k < NW; k++) if (!fnd && set[(wptr+k)%NW]) begin fnd = 1; f = (wptr+k)%NW; end
      if (dfc[f] >= pl[f]) begin g = 1; gw = f; end else rep = 1;
    end
    e.g = g; e.wq = gw; e.fq = pf[gw];
    sbq.push_back(e);
    for (int i = 0; i < NW; i++) begin
      int d = (g && gw == i) ? pl[i] : 0;
      if (n_we && n_wq == i) begin
        cb[i] = n_cbs; eb[i] = n_ebs; cbs[i] = n_cbs; ebs[i] = n_ebs;
        cir[i] = n_cir; eir[i] = n_eir;
      end else begin
        cb[i] = cb[i] - d + (n_tick ? cir[i] : 0); if (cb[i] > cbs[i]) cb[i] = cbs[i];
        eb[i] = eb[i] - d + (n_tick ? eir[i] : 0); if (eb[i] > ebs[i]) eb[i] = ebs[i];
      end
      if ((n_we && n_wq == i) || !act[i] || strm[i]) dfc[i] = 0;
      else if (drr && g && f == i) dfc[i] -= pl[i];
      else if (rep && f == i) dfc[i] += wgt[i] * BQ;
      if (g && gw == i) fqp[i] = (pf[i] + 1) % NF;
    end
    if (drr) wptr = g ? f : (f + 1) % NW;
    if (n_we) begin strm[n_wq] = n_strict; wgt[n_wq] = n_wgt; end
  endtask

  task automatic monitor();
    exp_t e;
    if (!rst_n) begin
      chk(grant_o == 1'b0, "R1", "grant in reset", int'(grant_o), 0);
      chk(deq_o == '0, "R1", "deq in reset", int'(deq_o), 0);
    end
    if (sbq.size() == 0) return;
    e = sbq.pop_front();
    chk(grant_o == e.g, tag, "grant", int'(grant_o), int'(e.g));
    if (e.g && grant_o) begin
      chk(int'(grant_wq_o) == e.wq, tag, "work queue", int'(grant_wq_o), e.wq);
      chk(int'(grant_fq_o) == e.fq, tag, "frame queue", int'(grant_fq_o), e.fq);
    end
    if (grant_o) chk(deq_o == (NQ'(1) << (int'(grant_wq_o)*NF + int'(grant_fq_o))), "R2", "deq one-hot",
                     int'(deq_o), int'(NQ'(1) << (int'(grant_wq_o)*NF + int'(grant_fq_o))));
    else chk(deq_o == '0, "R2", "deq idle", int'(deq_o), 0);
  endtask

  task automatic cycle();
    @(negedge clk);
    monitor();
    rst_n = n_rst; tick_i = n_tick; cfg_we_i = n_we; cfg_wq_i = 3'(n_wq);
    cfg_strict_i = n_strict; cfg_weight_i = WGT_W'(n_wgt);
    cfg_cir_i = RATE_W'(n_cir); cfg_eir_i = RATE_W'(n_eir);
    cfg_cbs_i = BURST_W'(n_cbs); cfg_ebs_i = BURST_W'(n_ebs);
    fq_backlog_i = n_bl;
    for (int j = 0; j < NQ; j++) fq_head_len_i[j*LEN_W +: LEN_W] = LEN_W'(n_len[j]);
    if (n_rst) predict(); else begin model_reset(); sbq.delete(); end
  endtask

  function automatic bit [15:0] lstep(input bit [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic set_lens(input int salt);
    for (int j = 0; j < NQ; j++) n_len[j] = 40 + ((j*37 + salt*11) % 200);
  endtask

  task automatic cfg(input int w, input bit s, input int wt, input int ci, input int ei, input int cbv, input int ebv);
    n_we = 1; n_wq = w; n_strict = s; n_wgt = wt; n_cir = ci; n_eir = ei; n_cbs = cbv; n_ebs = ebv;
    cycle();
    n_we = 0;
  endtask

  task automatic run(input int n, input string t, input int mode, input int tper);
    tag = t;
    for (int c = 0; c < n; c++) begin
      bit [15:0] a, b;
      lf = lstep(lf); a = lf; lf = lstep(lf); b = lf;
      case (mode)
        0: n_bl = '1;
        1: n_bl = {a, b};
        2: n_bl = {a & b, b & lstep(a)};
        default: n_bl = '0;
      endcase
      n_tick = (tper > 0) && (c % tper == 0);
      cycle();
    end
    n_tick = 0;
  endtask

  initial begin
    model_reset();
    set_lens(0);
    for (int c = 0; c < 4; c++) cycle();
    n_rst = 1;
    // R1: reset state seen through behaviour (all weighted, weight 1, zero buckets)
    run(40, "R1", 0, 0);
    // R9: host writes while idle
    n_bl = '0; tag = "R9";
    for (int w = 0; w < NW; w++) cfg(w, 0, 1 + w % 3, 0, 0, 200000, 200000);
    run(2, "R9", 3, 0);
    set_lens(1);
    run(150, "R5", 0, 0);
    set_lens(2);
    run(150, "R6", 1, 0);
    run(100, "R8", 2, 0);
    run(20, "R8", 3, 0);
    // R4: strict classes mixed with weighted, writes issued while traffic flows
    tag = "R9";
    n_bl = '1;
    cfg(2, 1, 1, 50, 50, 600, 300);
    cfg(5, 1, 1, 50, 50, 600, 300);
    run(200, "R4", 0, 8);
    // R3: small committed bursts, larger excess
    tag = "R9";
    for (int w = 0; w < NW; w++) cfg(w, w == 6, 1 + w % 4, 20, 40, 500, 1500);
    set_lens(3);
    run(300, "R3", 1, 3);
    // R7: refill on every cycle coinciding with debits
    tag = "R9";
    for (int w = 0; w < NW; w++) cfg(w, w == 1, 2, 100, 60, 400, 800);
    run(300, "R7", 0, 1);
    run(60, "R3", 0, 0);
    n_bl = '0;
    cycle();
    cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule